// File: doc/BRIEF.md
# Character-Synchronous Receiver with Hunt

This block receives a bit-serial, character-oriented synchronous stream and turns it into parallel characters. After reset it is in the hunt phase. In that phase it shifts in each qualified bit and looks for a programmed synchronisation pattern. The pattern is one 8-bit character, a 16-bit pair of characters, or a pulse on an external sync pin. When the pattern is found, the block leaves the hunt phase and frames characters of a programmable length, least significant bit first. Each character may be followed by a parity bit.

The surrounding logic supplies a serial bit together with a bit-clock enable, the static configuration, and a strobe that forces a new hunt. A disabled receiver also returns to the hunt phase, whether it is disabled by its enable bit or by loss of carrier while automatic enabling is selected. Characters equal to the sync character can be dropped rather than presented.

Top module: `sync_char_rx`

## Requirements
- R1: After reset, `hunting` is 1 and `sync_found`, `char_valid`, `char_data` and `parity_err` are 0.
- R2: With `sync_mode`=00, the hunt ends on the qualified bit that completes the last 8 received bits, taken LSB first, equal to `sync_b`. In the cycle after that bit, `sync_found` is 1 for exactly one cycle and `hunting` falls to 0.
- R3: With `sync_mode`=01, the hunt ends when the last 16 received bits match. The first 8 of those bits must equal `sync_a` and the next 8 must equal `sync_b`, each taken LSB first.
- R4: With `sync_mode`=11, a qualified bit with `ext_sync`=1 ends the hunt. That bit is discarded, and the first character starts on the next qualified bit.
- R5: With `sync_mode`=10, the receiver stays in the hunt phase and never raises `sync_found`.
- R6: `len_code` selects the character length: 00 gives 5 bits, 10 gives 6, 01 gives 7 and 11 gives 8. Bits arrive LSB first. `char_data` is right-aligned with its unused upper bits at 0, and `char_valid` pulses for one cycle in the cycle after the last bit of the character.
- R7: With `par_en`=1, one parity bit follows the data bits. `parity_err` is set with the character when the number of 1s in data plus parity is odd and `par_odd`=0, or even and `par_odd`=1.
- R8: With `drop_sync`=1, a completed character whose data equals the low bits of `sync_b` (masked to the character length) gives no `char_valid`, and `char_data` and `parity_err` keep their previous values.
- R9: A `hunt_cmd` strobe puts the receiver back into the hunt phase in the next cycle and discards any partly received character.
- R10: The receiver is inactive when `rx_enable`=0, or when `auto_en`=1 and `carrier`=0. While inactive it stays in the hunt phase and accepts no bits.
- R11: Bits and `ext_sync` values in cycles with `bit_en`=0 have no effect.
- R12: In the 8-bit and 16-bit modes, a match needs at least 8 or 16 bits, respectively, received since the hunt phase was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Qualifies `rx_bit` and `ext_sync` for this cycle |
| rx_bit | input | 1 | Serial data bit |
| ext_sync | input | 1 | External sync indication (mode 11) |
| rx_enable | input | 1 | Receiver enable |
| auto_en | input | 1 | Gate the receiver with `carrier` |
| carrier | input | 1 | Carrier present |
| sync_mode | input | 2 | 00 one char, 01 two chars, 10 unsupported, 11 external |
| len_code | input | 2 | Character length code |
| sync_a | input | 8 | First sync character (16-bit mode) |
| sync_b | input | 8 | Receive sync character |
| drop_sync | input | 1 | Drop characters equal to `sync_b` |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| hunt_cmd | input | 1 | Strobe: re-enter the hunt phase |
| char_data | output | 8 | Last presented character |
| char_valid | output | 1 | One-cycle character strobe |
| sync_found | output | 1 | One-cycle pulse when the hunt ends |
| hunting | output | 1 | High while in the hunt phase |
| parity_err | output | 1 | Parity result of the last presented character |

## Verification
The bench uses the default `CHAR_W` of 8, which makes the 16-bit pattern register and all four length codes, 5 to 8 bits, reachable. The cases covered are:
- a 16-bit match straddling two characters;
- a 5-bit character that is compared with only the low bits of the sync character;
- both parity senses, including deliberately corrupted parity bits.

Each bit is followed by a random gap of idle cycles, so every alignment of qualified bits against the clock occurs.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    typedef enum logic [1:0] {
        SM_ONE  = 2'b00,
        SM_TWO  = 2'b01,
        SM_BITS = 2'b10,
        SM_EXT  = 2'b11
    } sync_mode_e;

    // Length code: 00->w-3, 10->w-2, 01->w-1, 11->w (bit-reversed offset)
    function automatic int char_bits(input logic [1:0] code, input int w);
        return w - 3 + int'({code[0], code[1]});
    endfunction

endpackage

// File: rtl/sync_rx_hunter.sv
module sync_rx_hunter
    import sync_rx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              rx_bit,
    input  logic              ext_sync,
    input  sync_mode_e        mode,
    input  logic [CHAR_W-1:0] sync_a,
    input  logic [CHAR_W-1:0] sync_b,
    output logic              match
);
    localparam int SYNC_W = 2 * CHAR_W;
    localparam int FILL_W = $clog2(SYNC_W + 1);

    typedef struct packed {
        logic [SYNC_W-1:0] sh;
        logic [FILL_W-1:0] fill;
    } hunt_t;

    hunt_t q, d;
    logic [SYNC_W-1:0] nxt_sh;
    logic [FILL_W-1:0] fill_inc;

    always_comb begin
        d        = q;
        nxt_sh   = {rx_bit, q.sh[SYNC_W-1:1]};
        fill_inc = (q.fill == FILL_W'(SYNC_W)) ? q.fill : q.fill + 1'b1;
        match    = 1'b0;
        if (clear) begin
            d = '0;
        end else if (shift) begin
            d.sh   = nxt_sh;
            d.fill = fill_inc;
            unique case (mode)
                SM_ONE:  match = (fill_inc >= FILL_W'(CHAR_W)) &&
                                 (nxt_sh[SYNC_W-1 -: CHAR_W] == sync_b);
                SM_TWO:  match = (fill_inc == FILL_W'(SYNC_W)) &&
                                 (nxt_sh == {sync_b, sync_a});
                SM_EXT:  match = ext_sync;
                default: match = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R12
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fill <= FILL_W'(SYNC_W));

endmodule

// File: rtl/sync_rx_framer.sv
module sync_rx_framer
    import sync_rx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              rx_bit,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              perr
);
    localparam int CNT_W = $clog2(CHAR_W + 2);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] acc;
        logic              par;
    } frm_t;

    frm_t q, d;
    logic [CNT_W-1:0] nbits;
    logic [CNT_W-1:0] total;

    always_comb begin
        d     = q;
        done  = 1'b0;
        data  = '0;
        perr  = 1'b0;
        nbits = CNT_W'(char_bits(len_code, CHAR_W));
        total = nbits + CNT_W'(par_en);
        if (clear) begin
            d = '0;
        end else if (shift) begin
            if (q.cnt < nbits) begin
                d.acc[q.cnt] = rx_bit;
                d.par        = q.par ^ rx_bit;
            end
            if (q.cnt == total - 1'b1) begin
                done = 1'b1;
                data = d.acc;
                perr = par_en && ((q.par ^ rx_bit) != par_odd);
                d    = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(CHAR_W));

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import sync_rx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              ext_sync,
    input  logic              rx_enable,
    input  logic              auto_en,
    input  logic              carrier,
    input  logic [1:0]        sync_mode,
    input  logic [1:0]        len_code,
    input  logic [CHAR_W-1:0] sync_a,
    input  logic [CHAR_W-1:0] sync_b,
    input  logic              drop_sync,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              hunt_cmd,
    output logic [CHAR_W-1:0] char_data,
    output logic              char_valid,
    output logic              sync_found,
    output logic              hunting,
    output logic              parity_err
);
    typedef struct packed {
        logic              hunt;
        logic              found;
        logic              valid;
        logic [CHAR_W-1:0] data;
        logic              perr;
    } top_t;

    top_t q, d;
    logic active, restart, match, done, f_perr;
    logic [CHAR_W-1:0] f_data, mask;

    assign active  = rx_enable && (!auto_en || carrier);
    assign restart = !active || hunt_cmd;

    sync_rx_hunter #(.CHAR_W(CHAR_W)) u_hunter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart || !q.hunt),
        .shift    (bit_en && q.hunt),
        .rx_bit   (rx_bit),
        .ext_sync (ext_sync),
        .mode     (sync_mode_e'(sync_mode)),
        .sync_a   (sync_a),
        .sync_b   (sync_b),
        .match    (match)
    );

    sync_rx_framer #(.CHAR_W(CHAR_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart || q.hunt),
        .shift    (bit_en && !q.hunt),
        .rx_bit   (rx_bit),
        .len_code (len_code),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .done     (done),
        .data     (f_data),
        .perr     (f_perr)
    );

    always_comb begin
        d       = q;
        d.found = 1'b0;
        d.valid = 1'b0;
        mask    = {CHAR_W{1'b1}} >> (CHAR_W - char_bits(len_code, CHAR_W));
        if (restart) begin
            d.hunt = 1'b1;
        end else if (q.hunt) begin
            if (match) begin
                d.hunt  = 1'b0;
                d.found = 1'b1;
            end
        end else if (done) begin
            if (!(drop_sync && (f_data == (sync_b & mask)))) begin
                d.valid = 1'b1;
                d.data  = f_data;
                d.perr  = f_perr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.hunt <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign char_data  = q.data;
    assign char_valid = q.valid;
    assign sync_found = q.found;
    assign hunting    = q.hunt;
    assign parity_err = q.perr;

    // R2
    found_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> !sync_found);
    // R2
    found_leaves_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> !hunting);
    // R9
    cmd_rehunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> hunting);
    // R10
    inactive_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> hunting);
    // R5
    no_bitmode_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && sync_mode == 2'b10) |=> !sync_found);
    // R6
    valid_outside_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> !hunting);
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> ((char_data >> char_bits($past(len_code), CHAR_W)) == '0));

endmodule

// File: tb/sync_char_rx_tb.sv
module sync_char_rx_tb;
    logic clk = 0, rst_n = 0;
    logic bit_en = 0, rx_bit = 0, ext_sync = 0, rx_enable = 1, auto_en = 0, carrier = 1;
    logic [1:0] sync_mode = 0, len_code = 2'b11;
    logic [7:0] sync_a = 8'h3C, sync_b = 8'h96;
    logic drop_sync = 0, par_en = 0, par_odd = 0, hunt_cmd = 0;
    logic [7:0] char_data;
    logic char_valid, sync_found, hunting, parity_err;

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // reference model state
    bit m_hunt = 1, m_sf = 0, m_cv = 0, m_perr = 0;
    int m_data = 0;
    bit hist[$];
    bit cbits[$];

    always #2.5 clk = ~clk;

    sync_char_rx #(.CHAR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .ext_sync(ext_sync),
        .rx_enable(rx_enable), .auto_en(auto_en), .carrier(carrier), .sync_mode(sync_mode),
        .len_code(len_code), .sync_a(sync_a), .sync_b(sync_b), .drop_sync(drop_sync),
        .par_en(par_en), .par_odd(par_odd), .hunt_cmd(hunt_cmd), .char_data(char_data),
        .char_valid(char_valid), .sync_found(sync_found), .hunting(hunting),
        .parity_err(parity_err)
    );

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'b00: return 5;
            2'b10: return 6;
            2'b01: return 7;
            default: return 8;
        endcase
    endfunction

    task automatic model_update();
        bit act, hit;
        int n, tot, val, ones, sz, pat;
        m_sf = 0; m_cv = 0;
        if (!rst_n) begin
            m_hunt = 1; m_data = 0; m_perr = 0; hist.delete(); cbits.delete();
            return;
        end
        act = rx_enable && (!auto_en || carrier);
        if (!act || hunt_cmd) begin
            m_hunt = 1; hist.delete(); cbits.delete();
        end else if (m_hunt && bit_en) begin
            hist.push_back(rx_bit);
            if (hist.size() > 16) void'(hist.pop_front());
            sz = hist.size(); hit = 0;
            if (sync_mode == 2'b00 && sz >= 8) begin
                pat = 0;
                for (int i = 0; i < 8; i++) pat += int'(hist[sz-8+i]) << i;
                hit = (pat == int'(sync_b));
            end else if (sync_mode == 2'b01 && sz >= 16) begin
                pat = 0;
                for (int i = 0; i < 16; i++) pat += int'(hist[sz-16+i]) << i;
                hit = (pat == (int'(sync_b) * 256 + int'(sync_a)));
            end else if (sync_mode == 2'b11) begin
                hit = ext_sync;
            end
            if (hit) begin
                m_hunt = 0; m_sf = 1; hist.delete(); cbits.delete();
            end
        end else if (!m_hunt && bit_en) begin
            cbits.push_back(rx_bit);
            n = len_of(len_code); tot = n + int'(par_en);
            if (cbits.size() == tot) begin
                val = 0; ones = 0;
                for (int i = 0; i < tot; i++) begin
                    if (i < n) val += int'(cbits[i]) << i;
                    ones += int'(cbits[i]);
                end
                if (!(drop_sync && val == (int'(sync_b) % (1 << n)))) begin
                    m_cv = 1; m_data = val;
                    m_perr = par_en && ((ones % 2) != int'(par_odd));
                end
                cbits.delete();
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (hunting !== m_hunt || sync_found !== m_sf || char_valid !== m_cv ||
            int'(char_data) != m_data || parity_err !== m_perr) begin
            fails++;
            $display("FAIL %s: got hunt=%b sf=%b cv=%b data=%h perr=%b exp hunt=%b sf=%b cv=%b data=%h perr=%b",
                     cur_req, hunting, sync_found, char_valid, char_data, parity_err,
                     m_hunt, m_sf, m_cv, m_data[7:0], m_perr);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    // R11: idle cycles carry random bit and sync values that must be ignored
    task automatic send_bit(input bit b, input bit es = 0);
        bit_en = 1; rx_bit = b; ext_sync = es;
        step();
        bit_en = 0;
        repeat ($urandom_range(0, 2)) begin
            rx_bit = 1'($urandom); ext_sync = 1'($urandom);
            step();
        end
        ext_sync = 0;
    endtask

    task automatic send_rand(input int k);
        for (int i = 0; i < k; i++) send_bit(1'($urandom));
    endtask

    task automatic send_byte(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_char(input logic [7:0] v, input bit corrupt = 0);
        int n;
        bit p;
        n = len_of(len_code);
        p = par_odd;
        for (int i = 0; i < n; i++) p ^= v[i];
        send_byte(v, n);
        if (par_en) send_bit(p ^ corrupt);
    endtask

    task automatic pulse_cmd();
        hunt_cmd = 1; step(); hunt_cmd = 0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (got timeout, expected end)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst_n = 1;
        cur_req = "R1"; step();
        // R2 R12: single sync char after random noise
        cur_req = "R2"; sync_mode = 2'b00;
        send_rand(30); send_byte(sync_b, 8);
        // R6: every length code
        cur_req = "R6";
        for (int c = 0; c < 4; c++) begin
            len_code = 2'(c);
            for (int k = 0; k < 4; k++) send_char(8'($urandom));
        end
        // R8: sync-valued char with and without dropping (5-bit compares low bits)
        cur_req = "R8";
        len_code = 2'b11; send_char(sync_b); drop_sync = 1; send_char(sync_b); send_char(8'h55);
        len_code = 2'b00; send_char(sync_b & 8'h1F); send_char(8'h0A); drop_sync = 0;
        // R9: re-hunt mid-character
        cur_req = "R9"; len_code = 2'b11;
        send_bit(1); send_bit(0); send_bit(1); pulse_cmd();
        send_rand(5); send_byte(sync_b, 8); send_char(8'hA1);
        // R12: fewer than 8 bits after re-hunt do not match
        cur_req = "R12"; pulse_cmd(); send_byte(sync_b, 5); send_rand(3);
        // R3 R7: two-char pattern, parity
        cur_req = "R3"; sync_mode = 2'b01; pulse_cmd();
        send_rand(20); send_byte(sync_a, 8); send_byte(sync_b, 8);
        cur_req = "R7"; par_en = 1;
        for (int k = 0; k < 6; k++) begin
            par_odd = k[0]; len_code = 2'(k);
            send_char(8'($urandom), k[1]);
        end
        par_en = 0; par_odd = 0;
        // R4: external sync
        cur_req = "R4"; sync_mode = 2'b11; len_code = 2'b10; pulse_cmd();
        send_rand(6); send_bit(1, 1);
        for (int k = 0; k < 3; k++) send_char(8'($urandom));
        // R5: unsupported mode stays hunting
        cur_req = "R5"; sync_mode = 2'b10; pulse_cmd();
        send_rand(24); send_byte(sync_b, 8); send_bit(1, 1);
        // R10: disable by enable bit and by carrier loss
        cur_req = "R10"; sync_mode = 2'b00; len_code = 2'b11; pulse_cmd();
        send_byte(sync_b, 8); send_bit(1); send_bit(0);
        rx_enable = 0; step(); send_byte(sync_b, 8); rx_enable = 1;
        send_byte(sync_b, 8); send_char(8'h3E);
        auto_en = 1; carrier = 0; step(); send_byte(sync_b, 8);
        carrier = 1; send_byte(sync_b, 8); send_char(8'hC3); auto_en = 0;
        repeat (4) step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule